// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit sits between a core's execute stage and a 32-bit data memory bus. The core hands it one access at a time. Each access carries a byte address, a direction, a size (byte, halfword or word), a zero-extend flag for loads and, for stores, the data to write. On the bus side the unit always presents a word-aligned address. For stores it presents write data copied into every lane of the access size, with a 4-bit strobe that marks the bytes to update. For loads it picks the addressed byte or halfword out of the returned word and widens it to 32 bits. Loads are sign-extended unless the zero-extend flag is set.

Both the request side and the bus side use a valid/ready handshake. The core may present a request only while `req_ready` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Once taken, the bus request is held with unchanged address, data, strobe and direction until the memory raises `bus_ready`. A memory that answers in the same cycle works, and so does one that waits many cycles. During that time `busy` stays high and `req_ready` stays low. The result comes back as a one-cycle `rsp_valid` pulse in the cycle after the bus handshake. The response side has no back-pressure: the core stalls on `busy` and takes the result when it appears.

An access whose address does not suit its size never reaches the bus. Such an access ends with an `rsp_valid` pulse that carries `rsp_misalign`, one cycle after it is taken. The unit does not deliver traps.

Top module: `mem_lane_unit`

## Requirements
- R1: During and straight after reset, `bus_valid`, `rsp_valid`, `rsp_misalign` and `busy` are low and `req_ready` is high.
- R2: For a taken, aligned request, `bus_valid` rises in the next cycle. At that point `bus_addr` equals the request address with bits 1:0 cleared, and `bus_we` equals `req_write`.
- R3: Store strobes and write data use these size codes: 0 = byte, 1 = halfword, 2 = word. A byte store sets strobe bit `addr[1:0]` and copies data bits 7:0 into all four lanes. A halfword store sets strobe bits 1:0 when `addr[1]` is 0 and bits 3:2 when it is 1, and copies data bits 15:0 into both halves. A word store sets all four strobe bits and passes the data unchanged.
- R4: A byte load returns bits `8*addr[1:0]+7 : 8*addr[1:0]` of `bus_rdata`. The byte is sign-extended when `req_zext` is 0 and zero-extended when it is 1, so 0xFF gives 0xFFFFFFFF or 0x000000FF.
- R5: A halfword load returns `bus_rdata[15:0]` when `addr[1]` is 0 and `bus_rdata[31:16]` when it is 1. The halfword is sign- or zero-extended according to `req_zext`.
- R6: A word load returns `bus_rdata` unchanged, whatever the value of `req_zext`.
- R7: An access is misaligned if it is a halfword with `addr[0]` set, a word with either of `addr[1:0]` set, or uses size code 3. A misaligned access raises `rsp_valid` together with `rsp_misalign` in the cycle after it is taken, and `bus_valid` stays low.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_wdata`, `bus_strb` and `bus_we` hold their values and `bus_valid` stays high. `busy` stays high and `req_ready` stays low until the handshake.
- R9: `rsp_valid` is high for exactly the one cycle after the bus handshake, with `rsp_misalign` low. In that same cycle `bus_valid` is low and `req_ready` is high. A completed store returns `rsp_rdata` of zero.
- R10: During a load, `bus_strb` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Unit can take an access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_zext | input | 1 | Zero-extend the load result instead of sign-extending it |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Extended load result, zero for stores and faults |
| rsp_misalign | output | 1 | Completion was a misalignment fault |
| busy | output | 1 | A bus request is outstanding |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Memory accepts or answers the request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_strb | output | 4 | Per-byte write strobes |
| bus_rdata | input | 32 | Read word, sampled on the handshake edge |

## Verification
The assertions assume the core keeps to the request handshake. The core raises `req_valid` only for one cycle and only while `req_ready` is high. It never sends a new access while one is outstanding. The assertions also assume that `bus_ready` matters only while `bus_valid` is high. The stimulus keeps to these rules: every access runs to its response before the next begins, `bus_ready` is raised only after `bus_valid` has been seen, and `bus_rdata` is changed to a different value right after the handshake. A result that was not taken on the handshake edge would therefore show up as wrong data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic             we;
    acc_size_e        size;
    logic             zext;
    logic [OFS_W-1:0] ofs;
  } acc_ctx_t;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             fault
);
  always_comb begin
    unique case (size)
      SZ_BYTE: fault = 1'b0;
      SZ_HALF: fault = ofs[0];
      SZ_WORD: fault = |ofs;
      default: fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic              we,
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_strb
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LI = OFS_W'(i);
    localparam int HI = i % 2;
    logic [7:0] byte_v;
    logic       hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          byte_v = data[7:0];
          hit    = (ofs == LI);
        end
        SZ_HALF: begin
          byte_v = data[8*HI +: 8];
          hit    = (ofs[OFS_W-1] == LI[OFS_W-1]);
        end
        default: begin
          byte_v = data[8*i +: 8];
          hit    = 1'b1;
        end
      endcase
    end

    assign lane_data[8*i +: 8] = we ? byte_v : 8'h00;
    assign lane_strb[i]        = we & hit;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic              zext,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] value
);
  localparam int HALF_W = WORD_W / 2;

  logic [7:0]        sel_b;
  logic [HALF_W-1:0] sel_h;
  logic              sgn_b;
  logic              sgn_h;

  always_comb begin
    sel_b = rdata[8*ofs +: 8];
    sel_h = ofs[OFS_W-1] ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0];
    sgn_b = ~zext & sel_b[7];
    sgn_h = ~zext & sel_h[HALF_W-1];
    unique case (size)
      SZ_BYTE: value = {{(WORD_W-8){sgn_b}}, sel_b};
      SZ_HALF: value = {{(WORD_W-HALF_W){sgn_h}}, sel_h};
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_bus_ctrl.sv
module lsu_bus_ctrl
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              fault,
  input  acc_ctx_t          ctx_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] wdata_in,
  input  logic [LANES-1:0]  strb_in,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_strb,
  output acc_ctx_t          ctx_q,
  input  logic [WORD_W-1:0] load_val,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_misalign
);
  logic pend_q;
  logic accept;
  logic hs;

  assign req_ready = ~pend_q;
  assign accept    = req_valid & ~pend_q;
  assign hs        = pend_q & bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_rdata    <= '0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_strb     <= '0;
      ctx_q        <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      if (hs) begin
        pend_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= ctx_q.we ? '0 : load_val;
      end
      if (accept) begin
        if (fault) begin
          rsp_valid    <= 1'b1;
          rsp_misalign <= 1'b1;
          rsp_rdata    <= '0;
        end else begin
          pend_q    <= 1'b1;
          bus_addr  <= addr_in;
          bus_wdata <= wdata_in;
          bus_strb  <= strb_in;
          ctx_q     <= ctx_in;
        end
      end
    end
  end

  assign bus_valid = pend_q;
  assign bus_we    = ctx_q.we;
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_zext,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_misalign,
  output logic              busy,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_strb,
  input  logic [31:0]       bus_rdata
);
  acc_ctx_t          ctx_in;
  acc_ctx_t          ctx_q;
  logic              fault;
  logic [ADDR_W-1:0] addr_word;
  logic [WORD_W-1:0] lane_data;
  logic [LANES-1:0]  lane_strb;
  logic [WORD_W-1:0] load_val;

  assign ctx_in.we   = req_write;
  assign ctx_in.size = acc_size_e'(req_size);
  assign ctx_in.zext = req_zext;
  assign ctx_in.ofs  = req_addr[OFS_W-1:0];
  assign addr_word   = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  lsu_align_check u_align (
    .size  (ctx_in.size),
    .ofs   (ctx_in.ofs),
    .fault (fault)
  );

  lsu_store_lanes u_store (
    .we        (req_write),
    .size      (ctx_in.size),
    .ofs       (ctx_in.ofs),
    .data      (req_wdata),
    .lane_data (lane_data),
    .lane_strb (lane_strb)
  );

  lsu_load_extract u_load (
    .size  (ctx_q.size),
    .zext  (ctx_q.zext),
    .ofs   (ctx_q.ofs),
    .rdata (bus_rdata),
    .value (load_val)
  );

  lsu_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .fault        (fault),
    .ctx_in       (ctx_in),
    .addr_in      (addr_word),
    .wdata_in     (lane_data),
    .strb_in      (lane_strb),
    .bus_valid    (bus_valid),
    .bus_ready    (bus_ready),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_strb     (bus_strb),
    .ctx_q        (ctx_q),
    .load_val     (load_val),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_misalign (rsp_misalign)
  );

  assign busy = bus_valid;
endmodule

// File: rtl/mem_lane_unit_chk.sv
module mem_lane_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_misalign,
  input logic              busy,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        bus_strb
);
  logic bad_req;
  logic take;

  always_comb begin
    bad_req = (req_size == 2'd1 && req_addr[0]) ||
              (req_size == 2'd2 && req_addr[1:0] != 2'b00) ||
              (req_size == 2'd3);
    take = req_valid && req_ready;
  end

  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_addr[1:0] == 2'b00); // R2

  AST_TAKE_TO_BUS: assert property (@(posedge clk) disable iff (rst)
    take && !bad_req |=> bus_valid && bus_we == $past(req_write)
      && bus_addr[ADDR_W-1:2] == $past(req_addr[ADDR_W-1:2])); // R2

  AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_we |-> ($countones(bus_strb) == 1 ||
      $countones(bus_strb) == 2 || $countones(bus_strb) == 4)); // R3

  AST_MISALIGN_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    take && bad_req |=> !bus_valid && rsp_valid && rsp_misalign); // R7

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_wdata) && $stable(bus_strb) && $stable(bus_we)); // R8

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready); // R8

  AST_RSP_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready |=> rsp_valid && !rsp_misalign && !bus_valid); // R9

  AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_we |-> bus_strb == 4'b0000); // R10
endmodule

bind mem_lane_unit mem_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_size     (req_size),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_misalign (rsp_misalign),
  .busy         (busy),
  .bus_valid    (bus_valid),
  .bus_ready    (bus_ready),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_strb     (bus_strb)
);

// File: tb/tb_mem_lane_unit.sv
module tb_mem_lane_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_zext = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_misalign;
  logic        busy;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_strb;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_zext(req_zext),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign), .busy(busy),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_strb(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      2'd0: ref_strb = 4'b0001 << a;
      2'd1: ref_strb = a[1] ? 4'b1100 : 4'b0011;
      default: ref_strb = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: ref_wdata = {4{d[7:0]}};
      2'd1: ref_wdata = {2{d[15:0]}};
      default: ref_wdata = d;
    endcase
  endfunction

  function automatic logic [31:0] ref_load(input logic [1:0] sz, input bit zx,
                                           input logic [1:0] a, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    case (a)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = a[1] ? w[31:16] : w[15:0];
    case (sz)
      2'd0: ref_load = zx ? {24'h0, b} : {{24{b[7]}}, b};
      2'd1: ref_load = zx ? {16'h0, h} : {{16{h[15]}}, h};
      default: ref_load = w;
    endcase
  endfunction

  // One complete access; tag names the requirement of its data check.
  task automatic run_op(input bit w, input logic [1:0] sz, input bit zx,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] rw, input int lat, input string tag);
    bit mis;
    logic [31:0] c_addr, c_wdata;
    logic [3:0]  c_strb;
    mis = (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0) || (sz == 2'd3);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = w; req_size = sz; req_zext = zx;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      chk(bus_valid == 1'b0, "R7 no bus", 32'(bus_valid), 32'd0);
      chk(rsp_valid && rsp_misalign, "R7 fault rsp", {rsp_valid, rsp_misalign}, 32'd3);
      return;
    end
    chk(bus_valid == 1'b1, "R2 bus_valid", 32'(bus_valid), 32'd1);
    chk(bus_addr == {a[31:2], 2'b00}, "R2 addr", bus_addr, {a[31:2], 2'b00});
    chk(bus_we == w, "R2 we", 32'(bus_we), 32'(w));
    if (w) begin
      chk(bus_strb == ref_strb(sz, a[1:0]), "R3 strb", 32'(bus_strb), 32'(ref_strb(sz, a[1:0])));
      chk(bus_wdata == ref_wdata(sz, wd), "R3 wdata", bus_wdata, ref_wdata(sz, wd));
    end else begin
      chk(bus_strb == 4'b0000, "R10 load strb", 32'(bus_strb), 32'd0);
    end
    chk(busy && !req_ready, "R8 busy", {busy, req_ready}, 32'd2);
    c_addr = bus_addr; c_wdata = bus_wdata; c_strb = bus_strb;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk(bus_valid && busy && !req_ready, "R8 held valid", {bus_valid, busy, req_ready}, 32'd6);
      chk(bus_addr == c_addr && bus_wdata == c_wdata && bus_strb == c_strb,
          "R8 stable", bus_addr ^ c_addr ^ bus_wdata ^ c_wdata, 32'd0);
    end
    bus_ready = 1'b1; bus_rdata = rw;
    @(negedge clk);
    bus_ready = 1'b0; bus_rdata = 32'h5A5A_C3C3;
    chk(rsp_valid && !rsp_misalign, "R9 rsp", {rsp_valid, rsp_misalign}, 32'd2);
    chk(!bus_valid && req_ready, "R9 released", {bus_valid, req_ready}, 32'd1);
    chk(rsp_rdata == (w ? 32'h0 : ref_load(sz, zx, a[1:0], rw)), tag,
        rsp_rdata, w ? 32'h0 : ref_load(sz, zx, a[1:0], rw));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!bus_valid && !rsp_valid && !rsp_misalign && !busy && req_ready, "R1 in reset",
        {bus_valid, rsp_valid, rsp_misalign, busy, req_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_valid && !rsp_valid && !busy && req_ready, "R1 after reset",
        {bus_valid, rsp_valid, busy, req_ready}, 32'd1);
  endtask

  task automatic t_stores;
    for (int o = 0; o < 4; o++) run_op(1, 2'd0, 0, 32'h0000_1000 + o, 32'hCAFE_12A5, '0, 0, "R3 sb");
    run_op(1, 2'd1, 0, 32'h0000_2000, 32'h1111_BEEF, '0, 0, "R3 sh low");
    run_op(1, 2'd1, 0, 32'h0000_2002, 32'h1111_8001, '0, 1, "R3 sh high");
    run_op(1, 2'd2, 0, 32'h0000_3004, 32'hDEAD_0042, '0, 0, "R3 sw");
  endtask

  task automatic t_load_bytes;
    for (int o = 0; o < 4; o++) begin
      run_op(0, 2'd0, 0, 32'h0000_4000 + o, '0, 32'h7F80_FF01, 0, "R4 lb");
      run_op(0, 2'd0, 1, 32'h0000_4000 + o, '0, 32'h7F80_FF01, 0, "R4 lbu");
    end
  endtask

  task automatic t_load_halves;
    run_op(0, 2'd1, 0, 32'h0000_5000, '0, 32'h8001_7FFE, 0, "R5 lh low");
    run_op(0, 2'd1, 0, 32'h0000_5002, '0, 32'h8001_7FFE, 0, "R5 lh high");
    run_op(0, 2'd1, 1, 32'h0000_5002, '0, 32'h8001_7FFE, 0, "R5 lhu high");
    run_op(0, 2'd1, 1, 32'h0000_5000, '0, 32'hFFFF_8000, 0, "R5 lhu low");
  endtask

  task automatic t_load_word;
    run_op(0, 2'd2, 0, 32'h0000_6008, '0, 32'h8765_4321, 0, "R6 lw");
    run_op(0, 2'd2, 1, 32'h0000_600C, '0, 32'hF000_000F, 0, "R6 lw zext ignored");
  endtask

  task automatic t_misalign;
    run_op(0, 2'd1, 0, 32'h0000_7001, '0, '0, 0, "R7 lh odd");
    run_op(1, 2'd1, 0, 32'h0000_7003, 32'h1, '0, 0, "R7 sh odd");
    run_op(0, 2'd2, 0, 32'h0000_7002, '0, '0, 0, "R7 lw at 2");
    run_op(1, 2'd2, 0, 32'h0000_7001, 32'h1, '0, 0, "R7 sw at 1");
    run_op(0, 2'd3, 0, 32'h0000_7000, '0, '0, 0, "R7 reserved size");
    @(negedge clk);
    chk(!rsp_valid && !bus_valid, "R7 fault clears", {rsp_valid, bus_valid}, 32'd0);
    run_op(0, 2'd1, 0, 32'h0000_7002, '0, 32'h1234_5678, 0, "R5 after fault");
  endtask

  task automatic t_wait_states;
    run_op(0, 2'd2, 0, 32'h0000_8000, '0, 32'h0BAD_F00D, 6, "R8 lw slow");
    run_op(1, 2'd0, 0, 32'h0000_8003, 32'h0000_007E, '0, 3, "R8 sb slow");
    run_op(0, 2'd0, 0, 32'h0000_8002, '0, 32'h0080_0000, 4, "R8 lb slow");
  endtask

  initial begin
    t_reset();
    t_stores();
    t_load_bytes();
    t_load_halves();
    t_load_word();
    t_misalign();
    t_wait_states();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule